// File: doc/BRIEF.md
# Dual-Direction Mailbox Pair

This block carries single command words between two independently clocked ports, beside a data queue that flows from port A to port B. Mailbox one is loaded from port A and read at port B; mailbox two is loaded from port B and read at port A. Each mailbox holds one word. Loading it makes an active-low flag in the writer's clock domain go low. While that flag is low, further loads are refused. A read in the other domain releases the mailbox.

Each direction hands off with a pair of toggle bits. The writer flips one bit on every accepted load, and that bit is carried into the reader's domain through a flop chain. The reader flips its own bit when it consumes the word, and that bit is carried back the same way. The reader sees a "mail available" level in its own domain. Reads leave the stored word untouched. Port B's read path chooses between mailbox one and the queue's output word with the mailbox select. Port A's read path always shows mailbox two.

Top module: `mailbox_pair`

## Requirements
- R1: On a clk_a rising edge with a_cs_n=0, a_wr=1, a_en=1, a_mbx=1 and m1_flag_n=1, a_din is stored in mailbox one and m1_flag_n is 0 right after that edge.
- R2: On a clk_b rising edge with b_cs_n=0, b_wr=1, b_en=1, b_mbx=1 and m2_flag_n=1, b_din is stored in mailbox two and m2_flag_n is 0 right after that edge.
- R3: A load into a mailbox whose flag is 0 is ignored, so the stored word is unchanged.
- R4: After an accepted load, the reader's available bit (m1_avail in the clk_b domain, m2_avail in the clk_a domain) becomes 1 at the second reader-clock rising edge after the load edge.
- R5: On a clk_b rising edge with b_cs_n=0, b_wr=0, b_en=1, b_mbx=1 and m1_avail=1, m1_avail is 0 after that edge. m1_flag_n is still 0 after the first following clk_a edge and is 1 after the second.
- R6: On a clk_a rising edge with a_cs_n=0, a_wr=0, a_en=1, a_mbx=1 and m2_avail=1, m2_avail is 0 after that edge, and m2_flag_n returns to 1 two clk_b edges later.
- R7: A read does not change a mailbox's contents. A read while nothing is available has no effect on flags or data.
- R8: b_dout shows mailbox one when b_mbx=1 and fifo_q when b_mbx=0, whatever the state of the chip select, enable and direction inputs. a_dout always shows mailbox two.
- R9: While rst_n=0, both flags are 1, both available bits are 0 and both mailboxes hold zero.
- R10: A port operation with the chip select high, the enable low, or the mailbox select low does not touch any mailbox, flag or available bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction: 1 = load, 0 = read |
| a_en | input | 1 | Port A operation enable |
| a_mbx | input | 1 | Port A targets a mailbox |
| a_din | input | W | Port A write data |
| a_dout | output | W | Mailbox two contents |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction: 1 = load, 0 = read |
| b_en | input | 1 | Port B operation enable |
| b_mbx | input | 1 | Port B targets a mailbox; also the output mux select |
| b_din | input | W | Port B write data |
| fifo_q | input | W | Queue output register word for port B |
| b_dout | output | W | Mailbox one or fifo_q |
| m1_flag_n | output | 1 | Mailbox one occupied (low), clk_a domain |
| m2_flag_n | output | 1 | Mailbox two occupied (low), clk_b domain |
| m1_avail | output | 1 | Mailbox one has unread mail, clk_b domain |
| m2_avail | output | 1 | Mailbox two has unread mail, clk_a domain |

## Verification
A writer's flag falls right after the load edge. The data is on the read-side output at once. The reader's available bit rises at the second reader-clock edge after the load, and the writer's flag returns at the second writer-clock edge after the read. The bench offsets clk_b by a quarter period from clk_a and samples on falling edges. For the timing checks it samples just before and just after the second synchronising edge, so an extra or a missing stage is caught. The table-driven walks wait four cycles after each operation before comparing, so they check only settled values.

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
  parameter int W    = 36,
  parameter int SYNC = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs_n,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mbx,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  input  logic         b_cs_n,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mbx,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] fifo_q,
  output logic [W-1:0] b_dout,
  output logic         m1_flag_n,
  output logic         m2_flag_n,
  output logic         m1_avail,
  output logic         m2_avail
);

  logic [W-1:0]    mail1, mail2;
  logic            m1_wtog, m1_rtog, m2_wtog, m2_rtog;
  logic [SYNC-1:0] m1_ack_s, m1_wtog_s, m2_ack_s, m2_wtog_s;

  wire a_load = !a_cs_n &&  a_wr && a_en && a_mbx;
  wire a_read = !a_cs_n && !a_wr && a_en && a_mbx;
  wire b_load = !b_cs_n &&  b_wr && b_en && b_mbx;
  wire b_read = !b_cs_n && !b_wr && b_en && b_mbx;

  assign m1_flag_n = (m1_wtog == m1_ack_s[SYNC-1]);
  assign m2_flag_n = (m2_wtog == m2_ack_s[SYNC-1]);
  assign m1_avail  = m1_wtog_s[SYNC-1] ^ m1_rtog;
  assign m2_avail  = m2_wtog_s[SYNC-1] ^ m2_rtog;

  assign a_dout = mail2;
  assign b_dout = b_mbx ? mail1 : fifo_q;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1     <= '0;
      m1_wtog   <= 1'b0;
      m2_rtog   <= 1'b0;
      m1_ack_s  <= '0;
      m2_wtog_s <= '0;
    end else begin
      m1_ack_s  <= {m1_ack_s[SYNC-2:0], m1_rtog};
      m2_wtog_s <= {m2_wtog_s[SYNC-2:0], m2_wtog};
      if (a_load && m1_flag_n) begin
        mail1   <= a_din;
        m1_wtog <= ~m1_wtog;
      end
      if (a_read && m2_avail)
        m2_rtog <= ~m2_rtog;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2     <= '0;
      m2_wtog   <= 1'b0;
      m1_rtog   <= 1'b0;
      m2_ack_s  <= '0;
      m1_wtog_s <= '0;
    end else begin
      m2_ack_s  <= {m2_ack_s[SYNC-2:0], m2_rtog};
      m1_wtog_s <= {m1_wtog_s[SYNC-2:0], m1_wtog};
      if (b_load && m2_flag_n) begin
        mail2   <= b_din;
        m2_wtog <= ~m2_wtog;
      end
      if (b_read && m1_avail)
        m1_rtog <= ~m1_rtog;
    end
  end

endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
  parameter int W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic         a_cs_n,
  input logic         a_wr,
  input logic         a_en,
  input logic         a_mbx,
  input logic [W-1:0] a_din,
  input logic         b_cs_n,
  input logic         b_wr,
  input logic         b_en,
  input logic         b_mbx,
  input logic [W-1:0] b_din,
  input logic         m1_flag_n,
  input logic         m2_flag_n,
  input logic         m1_avail,
  input logic         m2_avail,
  input logic [W-1:0] mail1,
  input logic [W-1:0] mail2
);

  a_r1_load_mail1: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_cs_n && a_wr && a_en && a_mbx && m1_flag_n) |=> (!m1_flag_n && mail1 == $past(a_din)));

  a_r2_load_mail2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_cs_n && b_wr && b_en && b_mbx && m2_flag_n) |=> (!m2_flag_n && mail2 == $past(b_din)));

  a_r3_hold_mail1: assert property (@(posedge clk_a) disable iff (!rst_n)
    !m1_flag_n |=> $stable(mail1));

  a_r3_hold_mail2: assert property (@(posedge clk_b) disable iff (!rst_n)
    !m2_flag_n |=> $stable(mail2));

  a_r5_read_mail1: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_cs_n && !b_wr && b_en && b_mbx && m1_avail) |=> !m1_avail);

  a_r6_read_mail2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_cs_n && !a_wr && a_en && a_mbx && m2_avail) |=> !m2_avail);

endmodule

bind mailbox_pair mailbox_pair_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx), .a_din(a_din),
  .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx), .b_din(b_din),
  .m1_flag_n(m1_flag_n), .m2_flag_n(m2_flag_n),
  .m1_avail(m1_avail), .m2_avail(m2_avail),
  .mail1(mail1), .mail2(mail2)
);

// File: tb/sim_mailbox_pair.sv
module sim_mailbox_pair;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
  logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_q = 36'h7_7777_0001;
  logic [W-1:0] a_dout, b_dout;
  logic m1_flag_n, m2_flag_n, m1_avail, m2_avail;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_a = ~clk_a;
  initial begin #2; forever #4 clk_b = ~clk_b; end

  mailbox_pair #(.W(W)) u0 (.*);

  // op: 0 load mail1 at A, 1 read mail1 at B, 2 load mail2 at B, 3 read mail2 at A
  // fields: {op[1:0], data[35:0], exp_word[35:0], exp_flag_n, exp_avail}
  localparam logic [75:0] VEC [9] = '{
    {2'd0, 36'hA_5A5A_0F0F, 36'hA_5A5A_0F0F, 1'b0, 1'b1},
    {2'd0, 36'h3_C3C3_1234, 36'hA_5A5A_0F0F, 1'b0, 1'b1},
    {2'd1, 36'h0_0000_0000, 36'hA_5A5A_0F0F, 1'b1, 1'b0},
    {2'd1, 36'h0_0000_0000, 36'hA_5A5A_0F0F, 1'b1, 1'b0},
    {2'd0, 36'h3_C3C3_1234, 36'h3_C3C3_1234, 1'b0, 1'b1},
    {2'd2, 36'hF_0000_FFFF, 36'hF_0000_FFFF, 1'b0, 1'b1},
    {2'd2, 36'h1_2345_6789, 36'hF_0000_FFFF, 1'b0, 1'b1},
    {2'd3, 36'h0_0000_0000, 36'hF_0000_FFFF, 1'b1, 1'b0},
    {2'd1, 36'h0_0000_0000, 36'h3_C3C3_1234, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic wr, input logic en, input logic cs_n, input logic mbx, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
  endtask

  task automatic b_op(input logic wr, input logic en, input logic cs_n, input logic mbx, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = mbx; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_wr = 1'b0; b_en = 1'b0; b_mbx = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_a);
    @(negedge clk_b);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    b_mbx = 1'b1;
    #1;
    // R9: reset state
    chk("R9 m1_flag_n", {35'd0, m1_flag_n}, 36'd1);
    chk("R9 m2_flag_n", {35'd0, m2_flag_n}, 36'd1);
    chk("R9 m1_avail", {35'd0, m1_avail}, 36'd0);
    chk("R9 m2_avail", {35'd0, m2_avail}, 36'd0);
    chk("R9 mail2", a_dout, '0);
    chk("R9 mail1", b_dout, '0);
    repeat (3) @(negedge clk_a);
    rst_n = 1'b1;
    settle();

    // R8: output mux
    b_mbx = 1'b0; #1;
    chk("R8 b_dout fifo", b_dout, fifo_q);
    b_mbx = 1'b1; #1;
    chk("R8 b_dout mail1", b_dout, '0);

    // R10: non-mailbox or disabled port-A loads touch nothing
    a_op(1'b1, 1'b0, 1'b0, 1'b1, 36'h1_1111_1111);
    a_op(1'b1, 1'b1, 1'b1, 1'b1, 36'h2_2222_2222);
    a_op(1'b1, 1'b1, 1'b0, 1'b0, 36'h3_3333_3333);
    b_op(1'b1, 1'b1, 1'b0, 1'b0, 36'h4_4444_4444);
    settle();
    chk("R10 m1_flag_n", {35'd0, m1_flag_n}, 36'd1);
    chk("R10 m2_flag_n", {35'd0, m2_flag_n}, 36'd1);
    chk("R10 mail1", b_dout, '0);
    chk("R10 mail2", a_dout, '0);

    // table walk: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < 9; i++) begin
      logic [1:0] op;
      logic [W-1:0] d, ew;
      logic ef, ea;
      {op, d, ew, ef, ea} = VEC[i];
      case (op)
        2'd0: a_op(1'b1, 1'b1, 1'b0, 1'b1, d);
        2'd1: b_op(1'b0, 1'b1, 1'b0, 1'b1, d);
        2'd2: b_op(1'b1, 1'b1, 1'b0, 1'b1, d);
        default: a_op(1'b0, 1'b1, 1'b0, 1'b1, d);
      endcase
      settle();
      if (op < 2) begin
        chk("R1/R3/R5/R7 mail1 word", b_dout, ew);
        chk("R1/R5 m1_flag_n", {35'd0, m1_flag_n}, {35'd0, ef});
        chk("R4/R5 m1_avail", {35'd0, m1_avail}, {35'd0, ea});
      end else begin
        chk("R2/R3/R6/R7 mail2 word", a_dout, ew);
        chk("R2/R6 m2_flag_n", {35'd0, m2_flag_n}, {35'd0, ef});
        chk("R4/R6 m2_avail", {35'd0, m2_avail}, {35'd0, ea});
      end
    end

    // R4: available bit rises at the second clk_b edge after the load
    a_op(1'b1, 1'b1, 1'b0, 1'b1, 36'h5_0A0A_5555);
    chk("R1 immediate flag", {35'd0, m1_flag_n}, 36'd0);
    @(negedge clk_b);
    chk("R4 avail after 1st edge", {35'd0, m1_avail}, 36'd0);
    @(negedge clk_b);
    chk("R4 avail after 2nd edge", {35'd0, m1_avail}, 36'd1);
    settle();

    // R10: port-B queue read (mailbox select low) leaves mail pending
    b_op(1'b0, 1'b1, 1'b0, 1'b0, '0);
    settle();
    chk("R10 avail kept", {35'd0, m1_avail}, 36'd1);

    // R5: flag release timing in the clk_a domain
    b_op(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R5 avail cleared", {35'd0, m1_avail}, 36'd0);
    @(negedge clk_a);
    chk("R5 flag after 1st clk_a edge", {35'd0, m1_flag_n}, 36'd0);
    @(negedge clk_a);
    chk("R5 flag after 2nd clk_a edge", {35'd0, m1_flag_n}, 36'd1);
    chk("R7 word kept after read", b_dout, 36'h5_0A0A_5555);

    // R6: flag release timing in the clk_b domain
    b_op(1'b1, 1'b1, 1'b0, 1'b1, 36'h6_6666_0000);
    settle();
    a_op(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chk("R6 avail cleared", {35'd0, m2_avail}, 36'd0);
    settle();
    chk("R6 flag released", {35'd0, m2_flag_n}, 36'd1);
    chk("R8 a_dout mail2", a_dout, 36'h6_6666_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule